// File: doc/BRIEF.md
# Refresh Deadline Guard

This block works next to a memory command timing checker. For each candidate command the checker proposes an earliest start cycle. The guard compares that cycle with the next scheduled refresh. If the command would still be running when the banks must be closed for that refresh, the guard moves its start to the first cycle after the refresh has recovered. The guard never issues refreshes. A separate input tells it that a refresh was issued, and the guard then moves its deadlines forward by one refresh interval.

Three modes exist. In the all-bank mode one deadline pair covers the whole device: the close-all deadline and the refresh deadline. In the per-bank mode every bank has its own pair, and the pairs are staggered one clock apart. Only the addressed bank's pair is tested and moved forward. In the bypass mode every command passes through unchanged and refresh reports are ignored. All cycle values are absolute cycle numbers counted from reset. They are held in wide unsigned registers so they do not wrap.

Top module: `refresh_deadline_guard`

## Requirements
- R1: After reset, resultValid and resultDeferred are low.
- R2: In all-bank mode, an activate (kind 0) whose earliest start is at or after closeDeadline − T_RAS is moved to refreshDeadline + T_RFC. The initial refreshDeadline is T_REFI and the initial closeDeadline is T_REFI − T_RP.
- R3: In all-bank mode, a read (kind 1) at or after closeDeadline − T_RTP is moved to refreshDeadline + T_RFC.
- R4: In all-bank mode, a write (kind 2) at or after closeDeadline − (T_WL + T_BURST + T_WR) is moved to refreshDeadline + T_RFC.
- R5: In all-bank mode, a precharge (kind 3) at or after closeDeadline is moved to refreshDeadline + T_RFC.
- R6: A command below its threshold leaves with its earliest start unchanged and resultDeferred low. A moved command has resultDeferred high.
- R7: Each refresh reported in all-bank mode advances both all-bank deadlines by T_REFI.
- R8: In per-bank mode (modeSel 2), bank b starts with refreshDeadline T_REFI − (NUM_BANKS − 1) + b. Its ACT/RD/WR thresholds follow the R2–R4 offsets against that bank's own closeDeadline.
- R9: In per-bank mode, a bank's closeDeadline is its refreshDeadline minus max(NUM_BANKS, T_RP). A refresh report advances only the pair of refreshBank, by T_REFI.
- R10: In per-bank mode, a precharge is never moved.
- R11: In bypass mode (modeSel 0 or 3), every command passes unchanged and refresh reports do not advance any deadline.
- R12: A query presented in cycle n produces resultValid in cycle n+1. resultValid is low when no query was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | 0 bypass, 1 all-bank, 2 per-bank, 3 bypass |
| queryValid | input | 1 | Command query present |
| queryKind | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| queryBank | input | BANK_W | Target bank of the query |
| queryEarliest | input | CNT_W | Earliest start cycle proposed by the timing checker |
| refreshDone | input | 1 | A refresh was issued this cycle |
| refreshBank | input | BANK_W | Bank of the issued refresh (per-bank mode) |
| resultValid | output | 1 | Result of last cycle's query |
| resultEarliest | output | CNT_W | Earliest start after refresh adjustment |
| resultDeferred | output | 1 | Start was moved behind a refresh |

## Verification
The assertions check on every cycle that a query produces a result with a one-cycle latency. They also check that a result is unchanged whenever it is not flagged as moved, that the bypass mode never moves a command, and that a per-bank precharge is never moved. Only the bench scenarios can show the exact thresholds for each command kind, the staggered per-bank deadlines, and the refresh target value. They also show that a refresh advances only the addressed pair, or no pair at all in bypass mode. These properties depend on deadline state that the bench can see only through the outputs.

// File: rtl/rdg_pkg.sv
package rdg_pkg;
  typedef enum logic [1:0] {
    KIND_ACT = 2'd0,
    KIND_RD  = 2'd1,
    KIND_WR  = 2'd2,
    KIND_PRE = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    MODE_BYPASS  = 2'd0,
    MODE_ALLBANK = 2'd1,
    MODE_PERBANK = 2'd2,
    MODE_SPARE   = 2'd3
  } guard_mode_e;

  typedef struct packed {
    logic capture;
    logic chkAct;
    logic chkRd;
    logic chkWr;
    logic chkPre;
    logic bankMode;
    logic advAll;
    logic advBank;
  } guard_strobes_t;
endpackage

// File: rtl/rdg_ctrl.sv
module rdg_ctrl
  import rdg_pkg::*;
(
  input  logic [1:0]     modeSel,
  input  logic           queryValid,
  input  logic [1:0]     queryKind,
  input  logic           refreshDone,
  output guard_strobes_t strobes
);
  guard_mode_e mode;
  cmd_kind_e   kind;
  logic        isAll;
  logic        isPer;

  always_comb begin
    mode  = guard_mode_e'(modeSel);
    kind  = cmd_kind_e'(queryKind);
    isAll = (mode == MODE_ALLBANK);
    isPer = (mode == MODE_PERBANK);

    strobes          = '0;
    strobes.capture  = queryValid;
    strobes.bankMode = isPer;
    if (queryValid && (isAll || isPer)) begin
      unique case (kind)
        KIND_ACT: strobes.chkAct = 1'b1;
        KIND_RD:  strobes.chkRd  = 1'b1;
        KIND_WR:  strobes.chkWr  = 1'b1;
        KIND_PRE: strobes.chkPre = isAll;
        default:  ;
      endcase
    end
    strobes.advAll  = refreshDone && isAll;
    strobes.advBank = refreshDone && isPer;
  end
endmodule

// File: rtl/rdg_datapath.sv
module rdg_datapath
  import rdg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 32,
  parameter int T_REFI    = 100,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 8,
  parameter int T_RTP     = 2,
  parameter int T_WL      = 2,
  parameter int T_BURST   = 4,
  parameter int T_WR      = 3,
  parameter int T_RFC     = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  guard_strobes_t    strobes,
  input  logic [BANK_W-1:0] queryBank,
  input  logic [CNT_W-1:0]  queryEarliest,
  input  logic [BANK_W-1:0] refreshBank,
  output logic              resultValid,
  output logic [CNT_W-1:0]  resultEarliest,
  output logic              resultDeferred
);
  localparam int WR_LEAD   = T_WL + T_BURST + T_WR;
  localparam int PB_GAP    = (NUM_BANKS > T_RP) ? NUM_BANKS : T_RP;
  localparam int PB_FIRST  = T_REFI - (NUM_BANKS - 1);

  logic [CNT_W-1:0] allRef;
  logic [CNT_W-1:0] allPre;
  logic [CNT_W-1:0] bankRef [NUM_BANKS];
  logic [CNT_W-1:0] bankPre [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allRef <= CNT_W'(T_REFI);
      allPre <= CNT_W'(T_REFI - T_RP);
    end else if (strobes.advAll) begin
      allRef <= allRef + CNT_W'(T_REFI);
      allPre <= allPre + CNT_W'(T_REFI);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankRef[b] <= CNT_W'(PB_FIRST + b);
        bankPre[b] <= CNT_W'(PB_FIRST + b - PB_GAP);
      end else if (strobes.advBank && (refreshBank == BANK_W'(b))) begin
        bankRef[b] <= bankRef[b] + CNT_W'(T_REFI);
        bankPre[b] <= bankPre[b] + CNT_W'(T_REFI);
      end
    end
  end

  logic [CNT_W-1:0] selRef;
  logic [CNT_W-1:0] selPre;
  logic [CNT_W-1:0] lead;
  logic [CNT_W-1:0] threshold;
  logic             anyChk;
  logic             hit;
  logic [CNT_W-1:0] nextEarliest;

  always_comb begin
    selRef = strobes.bankMode ? bankRef[queryBank] : allRef;
    selPre = strobes.bankMode ? bankPre[queryBank] : allPre;
    if (strobes.chkAct)      lead = CNT_W'(T_RAS);
    else if (strobes.chkRd)  lead = CNT_W'(T_RTP);
    else if (strobes.chkWr)  lead = CNT_W'(WR_LEAD);
    else                     lead = '0;
    threshold    = selPre - lead;
    anyChk       = strobes.chkAct | strobes.chkRd | strobes.chkWr | strobes.chkPre;
    hit          = anyChk && (queryEarliest >= threshold);
    nextEarliest = hit ? (selRef + CNT_W'(T_RFC)) : queryEarliest;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid    <= 1'b0;
      resultEarliest <= '0;
      resultDeferred <= 1'b0;
    end else begin
      resultValid <= strobes.capture;
      if (strobes.capture) begin
        resultEarliest <= nextEarliest;
        resultDeferred <= hit;
      end else begin
        resultDeferred <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/refresh_deadline_guard.sv
module refresh_deadline_guard
  import rdg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 32,
  parameter int T_REFI    = 100,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 8,
  parameter int T_RTP     = 2,
  parameter int T_WL      = 2,
  parameter int T_BURST   = 4,
  parameter int T_WR      = 3,
  parameter int T_RFC     = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              queryValid,
  input  logic [1:0]        queryKind,
  input  logic [BANK_W-1:0] queryBank,
  input  logic [CNT_W-1:0]  queryEarliest,
  input  logic              refreshDone,
  input  logic [BANK_W-1:0] refreshBank,
  output logic              resultValid,
  output logic [CNT_W-1:0]  resultEarliest,
  output logic              resultDeferred
);
  guard_strobes_t strobes;

  rdg_ctrl u_ctrl (
    .modeSel     (modeSel),
    .queryValid  (queryValid),
    .queryKind   (queryKind),
    .refreshDone (refreshDone),
    .strobes     (strobes)
  );

  rdg_datapath #(
    .NUM_BANKS (NUM_BANKS), .CNT_W (CNT_W), .T_REFI (T_REFI), .T_RP (T_RP),
    .T_RAS (T_RAS), .T_RTP (T_RTP), .T_WL (T_WL), .T_BURST (T_BURST),
    .T_WR (T_WR), .T_RFC (T_RFC)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .queryBank      (queryBank),
    .queryEarliest  (queryEarliest),
    .refreshBank    (refreshBank),
    .resultValid    (resultValid),
    .resultEarliest (resultEarliest),
    .resultDeferred (resultDeferred)
  );
endmodule

// File: rtl/rdg_checker.sv
module rdg_checker #(
  parameter int CNT_W  = 32,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              queryValid,
  input logic [1:0]        queryKind,
  input logic [BANK_W-1:0] queryBank,
  input logic [CNT_W-1:0]  queryEarliest,
  input logic              resultValid,
  input logic [CNT_W-1:0]  resultEarliest,
  input logic              resultDeferred
);
  logic unusedBank;
  assign unusedBank = ^queryBank;

  // R12
  result_follows_query_chk: assert property (@(posedge clk) disable iff (!rstN)
    queryValid |=> resultValid);

  // R12
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !queryValid |=> !resultValid);

  // R6
  unmoved_keeps_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    queryValid |=> (resultDeferred || (resultEarliest == $past(queryEarliest))));

  // R11
  bypass_passes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (queryValid && ((modeSel == 2'd0) || (modeSel == 2'd3)))
      |=> (!resultDeferred && (resultEarliest == $past(queryEarliest))));

  // R10
  perbank_pre_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (queryValid && (modeSel == 2'd2) && (queryKind == 2'd3)) |=> !resultDeferred);
endmodule

bind refresh_deadline_guard rdg_checker #(.CNT_W(CNT_W), .BANK_W(BANK_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .modeSel        (modeSel),
  .queryValid     (queryValid),
  .queryKind      (queryKind),
  .queryBank      (queryBank),
  .queryEarliest  (queryEarliest),
  .resultValid    (resultValid),
  .resultEarliest (resultEarliest),
  .resultDeferred (resultDeferred)
);

// File: tb/refresh_deadline_guard_test.sv
module refresh_deadline_guard_test;
  localparam int NB = 4, CW = 32, REFI = 100, RP = 3, RAS = 8, RTP = 2;
  localparam int WL = 2, BURST = 4, WR = 3, RFC = 10;
  localparam int GAP = (NB > RP) ? NB : RP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'd1;
  logic queryValid = 1'b0;
  logic [1:0] queryKind = '0;
  logic [1:0] queryBank = '0;
  logic [CW-1:0] queryEarliest = '0;
  logic refreshDone = 1'b0;
  logic [1:0] refreshBank = '0;
  logic resultValid;
  logic [CW-1:0] resultEarliest;
  logic resultDeferred;

  always #10 clk = ~clk;

  refresh_deadline_guard uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .queryValid(queryValid),
    .queryKind(queryKind), .queryBank(queryBank), .queryEarliest(queryEarliest),
    .refreshDone(refreshDone), .refreshBank(refreshBank), .resultValid(resultValid),
    .resultEarliest(resultEarliest), .resultDeferred(resultDeferred)
  );

  typedef struct { longint val; bit defr; string req; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model of the deadlines, built from the requirements
  longint mAllRef = REFI;
  longint mBankRef [NB];
  initial for (int b = 0; b < NB; b++) mBankRef[b] = REFI - (NB - 1) + b;

  task automatic query(input int kind, input int bank, input longint e, input string req);
    exp_t x;
    longint ref_d, pre_d, lead;
    bit chk;
    bit per;
    per   = (modeSel == 2'd2);
    chk   = (modeSel == 2'd1) || (per && kind != 3);
    ref_d = per ? mBankRef[bank] : mAllRef;
    pre_d = per ? ref_d - GAP : ref_d - RP;
    lead  = (kind == 0) ? RAS : (kind == 1) ? RTP : (kind == 2) ? (WL + BURST + WR) : 0;
    x.defr = chk && (e >= pre_d - lead);
    x.val  = x.defr ? ref_d + RFC : e;
    x.req  = req;
    @(negedge clk);
    sb.push_back(x);
    queryValid = 1'b1; queryKind = 2'(kind); queryBank = 2'(bank); queryEarliest = CW'(e);
    @(negedge clk);
    queryValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic refresh(input int bank);
    @(negedge clk);
    refreshDone = 1'b1; refreshBank = 2'(bank);
    if (modeSel == 2'd1) mAllRef += REFI;
    else if (modeSel == 2'd2) mBankRef[bank] += REFI;
    @(negedge clk);
    refreshDone = 1'b0;
  endtask

  // monitor
  always @(negedge clk) if (rstN && resultValid) begin
    exp_t x;
    checks++;
    if (sb.size() == 0) begin
      fails++;
      $display("FAIL R12: result without query, actual valid=1 expected valid=0");
    end else begin
      x = sb.pop_front();
      if (resultEarliest != CW'(x.val) || resultDeferred != x.defr) begin
        fails++;
        $display("FAIL %s: actual %0d/%0b expected %0d/%0b", x.req,
                 resultEarliest, resultDeferred, x.val, x.defr);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (resultValid !== 1'b0 || resultDeferred !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual %b/%b expected 0/0", resultValid, resultDeferred);
    end
    rstN = 1'b1;
    @(negedge clk);
    // all-bank mode: refresh 100, close 97
    query(0, 0, 88, "R2");  query(0, 0, 89, "R2");
    query(1, 1, 94, "R3");  query(1, 1, 95, "R3");
    query(2, 2, 87, "R4");  query(2, 2, 88, "R4");
    query(3, 3, 96, "R5");  query(3, 3, 97, "R5");
    query(0, 0, 20, "R6");
    query(0, 0, 150, "R6");
    refresh(0);
    query(0, 0, 188, "R7"); query(0, 0, 189, "R7");
    // per-bank mode
    @(negedge clk); modeSel = 2'd2;
    query(0, 2, 86, "R8");  query(0, 2, 87, "R8");
    query(0, 0, 85, "R8");
    query(1, 1, 91, "R9");  query(1, 1, 92, "R9");
    query(2, 3, 86, "R9");  query(2, 3, 87, "R9");
    query(3, 0, 150, "R10");
    refresh(1);
    query(0, 1, 186, "R9"); query(0, 0, 186, "R9");
    // bypass mode: passes and ignores refreshes
    @(negedge clk); modeSel = 2'd0;
    query(0, 0, 500, "R11"); query(3, 0, 9999, "R11");
    refresh(0);
    @(negedge clk); modeSel = 2'd3;
    query(2, 1, 700, "R11");
    @(negedge clk); modeSel = 2'd1;
    query(0, 0, 188, "R11"); query(0, 0, 189, "R11");
    // idle cycles: no result may appear (R12)
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R12: actual %0d pending results expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule